// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns an instruction operand specifier into a physical memory address. The specifier carries a base register select, an index register select and a short displacement. The block adds the selected base register, the selected index register and the zero-extended displacement to form a virtual address. The virtual address is split into three fields: a segment number in the top bits, a page number below it, and an offset in the low bits.

The block then walks two tables that live in main memory. It makes the walk over a request/acknowledge read port, and each read waits for the one before it. The first read fetches the segment's entry from the segment table. The block reads it at the segment-table base register plus the segment number, and the entry gives the start of that segment's page table. The second read fetches the page entry at that start plus the page number. The physical address is the page entry plus the offset, formed by addition and not by concatenation.

A start pulse begins a walk, and a one-cycle done pulse marks the cycle in which the physical address is ready. The base, index and segment-table base registers are loaded through a write port. That port, like the start input, is ignored while a walk is in progress.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, busy, done and memReq are 0, physAddr is 0, and all base, index and segment-table base registers hold 0.
- R2: On an accepted start, the virtual address is base[baseSel] + index[indexSel] + zero-extended disp, taken modulo 2^VA_W.
- R3: The first read of a walk goes to segment-table base + segment field, modulo 2^ADDR_W. The segment field is the top SEG_W bits of the virtual address.
- R4: The second read goes to the first read's data + page field, modulo 2^ADDR_W. The page field is the PAGE_W bits just below the segment field.
- R5: physAddr is the second read's data + offset field, modulo 2^ADDR_W. The offset field is the low OFF_W bits of the virtual address.
- R6: memReq goes high in the cycle after the start is accepted. memReq and memAddr hold steady until a cycle with memValid high. Each walk makes exactly two reads, segment first and page second.
- R7: done is high for exactly one cycle, the cycle after the edge that accepts the second memValid. physAddr is valid in that cycle and keeps its value until the next walk completes.
- R8: busy is high from the cycle after an accepted start through the done cycle, and is low in the cycle after done. A start while busy is ignored.
- R9: A write with regWrEn loads regWrData into a register chosen by regWrTarget:
  - codes 0-3 load base 0-3;
  - codes 4-7 load index 0-3;
  - codes 8-15 load the segment-table base.
  
  The write is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Begin a translation (accepted when idle) |
| baseSel | input | SEL_W | Base register select |
| indexSel | input | SEL_W | Index register select |
| disp | input | DISP_W | Displacement, zero-extended |
| regWrEn | input | 1 | Register write strobe |
| regWrTarget | input | SEL_W+2 | Register write target code |
| regWrData | input | ADDR_W | Register write data |
| memReq | output | 1 | Table read request |
| memAddr | output | ADDR_W | Table read address |
| memValid | input | 1 | Read data valid |
| memRdata | input | ADDR_W | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | ADDR_W | Translated physical address |

## Verification
The assertions assume that memValid is only raised while memReq is high, and that memValid lasts one cycle per read. The bench's memory responder only answers an outstanding request, after zero to two wait cycles, and drops memValid on the next cycle. The assertions also assume a reset of at least one cycle before any traffic. The bench drives start and register writes during waits so that the ignore rules can be observed through the later read addresses and the busy output.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_SEG,
    WALK_PAGE,
    WALK_DONE
  } walkState_t;

  typedef struct packed {
    logic captureVa;
    logic capturePtBase;
    logic capturePhys;
    logic usePageAddr;
    logic readActive;
    logic walkBusy;
    logic walkDone;
  } walkStrobes_t;

endpackage

// File: rtl/segpage_ctrl.sv
module segpage_ctrl
  import segpage_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         memValid,
  output walkStrobes_t strobes,
  output logic         busy,
  output logic         done,
  output logic         memReq
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= WALK_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      WALK_IDLE: begin
        if (startIn) begin
          strobes.captureVa = 1'b1;
          stateNext         = WALK_SEG;
        end
      end
      WALK_SEG: begin
        strobes.readActive = 1'b1;
        if (memValid) begin
          strobes.capturePtBase = 1'b1;
          stateNext             = WALK_PAGE;
        end
      end
      WALK_PAGE: begin
        strobes.readActive  = 1'b1;
        strobes.usePageAddr = 1'b1;
        if (memValid) begin
          strobes.capturePhys = 1'b1;
          stateNext           = WALK_DONE;
        end
      end
      WALK_DONE: begin
        strobes.walkDone = 1'b1;
        stateNext        = WALK_IDLE;
      end
      default: stateNext = WALK_IDLE;
    endcase
    strobes.walkBusy = (state != WALK_IDLE);
  end

  assign busy   = (state != WALK_IDLE);
  assign done   = (state == WALK_DONE);
  assign memReq = (state == WALK_SEG) || (state == WALK_PAGE);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_req_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq);

  p_seg_then_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == WALK_SEG && memValid) |=> (state == WALK_PAGE && memReq));

  p_start_opens_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startIn) |=> (memReq && busy));

endmodule

// File: rtl/segpage_dp.sv
module segpage_dp
  import segpage_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8,
  parameter int DISP_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobes_t         strobes,
  input  logic [SEL_W-1:0]     baseSel,
  input  logic [SEL_W-1:0]     indexSel,
  input  logic [DISP_W-1:0]    disp,
  input  logic                 regWrEn,
  input  logic [SEL_W+1:0]     regWrTarget,
  input  logic [ADDR_W-1:0]    regWrData,
  input  logic                 memValid,
  input  logic [ADDR_W-1:0]    memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [ADDR_W-1:0]    physAddr
);

  localparam int VA_W     = SEG_W + PAGE_W + OFF_W;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int TGT_W    = SEL_W + 2;

  logic [NUM_REGS-1:0][VA_W-1:0] baseRegs;
  logic [NUM_REGS-1:0][VA_W-1:0] indexRegs;
  logic [ADDR_W-1:0]             stbrReg;
  logic [VA_W-1:0]               vaReg;
  logic [ADDR_W-1:0]             ptBaseReg;
  logic [ADDR_W-1:0]             physReg;

  logic wrAllowed;
  logic wrStbr;
  logic wrIndexBank;
  logic [SEL_W-1:0] wrSlot;

  assign wrAllowed   = regWrEn && !strobes.walkBusy;
  assign wrStbr      = regWrTarget[TGT_W-1];
  assign wrIndexBank = regWrTarget[TGT_W-2];
  assign wrSlot      = regWrTarget[SEL_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_regfile
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseRegs[g]  <= '0;
        indexRegs[g] <= '0;
      end else if (wrAllowed && !wrStbr && wrSlot == SEL_W'(g)) begin
        if (wrIndexBank) indexRegs[g] <= regWrData[VA_W-1:0];
        else             baseRegs[g]  <= regWrData[VA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  stbrReg <= '0;
    else if (wrAllowed && wrStbr) stbrReg <= regWrData;
  end

  logic [VA_W-1:0] vaNext;
  assign vaNext = baseRegs[baseSel] + indexRegs[indexSel]
                + {{(VA_W-DISP_W){1'b0}}, disp};

  logic [SEG_W-1:0]  segField;
  logic [PAGE_W-1:0] pageField;
  logic [OFF_W-1:0]  offField;
  assign segField  = vaReg[VA_W-1 -: SEG_W];
  assign pageField = vaReg[OFF_W +: PAGE_W];
  assign offField  = vaReg[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      ptBaseReg <= '0;
      physReg   <= '0;
    end else begin
      if (strobes.captureVa)     vaReg     <= vaNext;
      if (strobes.capturePtBase) ptBaseReg <= memRdata;
      if (strobes.capturePhys)
        physReg <= memRdata + {{(ADDR_W-OFF_W){1'b0}}, offField};
    end
  end

  assign memAddr = strobes.usePageAddr
                 ? ptBaseReg + {{(ADDR_W-PAGE_W){1'b0}}, pageField}
                 : stbrReg   + {{(ADDR_W-SEG_W){1'b0}},  segField};
  assign physAddr = physReg;

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readActive && !memValid) |=> $stable(memAddr));

  p_phys_only_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(physAddr) |-> strobes.walkDone);

  p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.walkBusy |=> ($stable(stbrReg) && $stable(baseRegs) && $stable(indexRegs)));

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8,
  parameter int DISP_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  indexSel,
  input  logic [DISP_W-1:0] disp,
  input  logic              regWrEn,
  input  logic [SEL_W+1:0]  regWrTarget,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr
);

  walkStrobes_t strobes;

  segpage_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .memValid (memValid),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done),
    .memReq   (memReq)
  );

  segpage_dp #(
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .DISP_W (DISP_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .baseSel     (baseSel),
    .indexSel    (indexSel),
    .disp        (disp),
    .regWrEn     (regWrEn),
    .regWrTarget (regWrTarget),
    .regWrData   (regWrData),
    .memValid    (memValid),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .physAddr    (physAddr)
  );

endmodule

// File: tb/tb_segpage_xlate.sv
module tb_segpage_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  baseSel = '0;
  logic [1:0]  indexSel = '0;
  logic [3:0]  disp = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrTarget = '0;
  logic [15:0] regWrData = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memValid = 1'b0;
  logic [15:0] memRdata = '0;
  logic        busy;
  logic        done;
  logic [15:0] physAddr;

  always #2 clk = ~clk;

  segpage_xlate dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseSel(baseSel),
    .indexSel(indexSel), .disp(disp), .regWrEn(regWrEn),
    .regWrTarget(regWrTarget), .regWrData(regWrData), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memRdata(memRdata),
    .busy(busy), .done(done), .physAddr(physAddr)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] mBase [4];
  logic [15:0] mIndex [4];
  logic [15:0] mStbr;

  function automatic logic [15:0] memFn(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'd40503;
    return m ^ 16'h2C5B;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] tgt, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrTarget = tgt; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    if (tgt[3])      mStbr = val;
    else if (tgt[2]) mIndex[tgt[1:0]] = val;
    else             mBase[tgt[1:0]] = val;
  endtask

  task automatic serve(input int lat, input logic [15:0] expAddr, input logic [15:0] data,
                       input bit meddle, input string req);
    for (int k = 0; k < lat; k++) begin
      if (meddle && k == 0) begin
        startIn = 1'b1; regWrEn = 1'b1; regWrTarget = 4'd8; regWrData = 16'h1111;
      end
      @(negedge clk);
      startIn = 1'b0; regWrEn = 1'b0;
      check(memReq === 1'b1, "R6 req held", memReq, 1);
      check(memAddr === expAddr, req, memAddr, expAddr);
    end
    memValid = 1'b1; memRdata = data;
    @(negedge clk);
    memValid = 1'b0; memRdata = '0;
  endtask

  task automatic walk(input int bs, input int is, input int dsp, input int lat, input bit meddle);
    logic [15:0] va, segAddr, segEnt, pgAddr, pgEnt, phys;
    va      = mBase[bs] + mIndex[is] + 16'(dsp);
    segAddr = mStbr + {12'd0, va[15:12]};
    segEnt  = memFn(segAddr);
    pgAddr  = segEnt + {12'd0, va[11:8]};
    pgEnt   = memFn(pgAddr);
    phys    = pgEnt + {8'd0, va[7:0]};
    @(negedge clk);
    startIn = 1'b1; baseSel = 2'(bs); indexSel = 2'(is); disp = 4'(dsp);
    @(negedge clk);
    startIn = 1'b0;
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    check(memReq === 1'b1, "R6 req after start", memReq, 1);
    check(memAddr === segAddr, "R3 segment read (R2 va)", memAddr, segAddr);
    serve(lat, segAddr, segEnt, meddle, "R3 segment addr held");
    check(memReq === 1'b1, "R6 second read", memReq, 1);
    check(memAddr === pgAddr, "R4 page read", memAddr, pgAddr);
    serve(lat, pgAddr, pgEnt, 1'b0, "R4 page addr held");
    check(done === 1'b1, "R7 done pulse", done, 1);
    check(physAddr === phys, "R5 physical address", physAddr, phys);
    check(memReq === 1'b0, "R6 two reads only", memReq, 0);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", done, 0);
    check(busy === 1'b0, "R8 idle after done", busy, 0);
    check(physAddr === phys, "R7 physAddr holds", physAddr, phys);
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mBase[i] = '0; mIndex[i] = '0; end
    mStbr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy reset", busy, 0);
    check(done === 1'b0, "R1 done reset", done, 0);
    check(memReq === 1'b0, "R1 req reset", memReq, 0);
    check(physAddr === 16'h0, "R1 phys reset", physAddr, 0);
    // R1: registers at zero -> walk sees only the displacement
    walk(1, 2, 5, 1, 1'b0);

    for (int i = 0; i < 4; i++) begin
      writeReg(4'(i), 16'(16'hC3A5 * (i + 1)));
      writeReg(4'(4 + i), 16'(16'h5D2F * (i + 3)));
    end
    writeReg(4'd8, 16'hFFF8);

    // R2..R8 near-exhaustive sweep over selects and displacement
    for (int bs = 0; bs < 4; bs++)
      for (int is = 0; is < 4; is++)
        for (int d = 0; d < 16; d++)
          walk(bs, is, d, (bs + is + d) % 3, 1'b0);

    // R9 and R8: write and start during a walk are ignored
    walk(2, 3, 9, 2, 1'b1);
    check(memReq === 1'b0, "R8 start while busy ignored", memReq, 0);
    walk(0, 1, 15, 1, 1'b0);

    // R9: writes while idle take effect, upper code range selects stbr
    writeReg(4'd15, 16'h0123);
    writeReg(4'd3, 16'hFFFF);
    writeReg(4'd6, 16'h0001);
    walk(3, 2, 15, 0, 1'b0);
    walk(3, 2, 0, 2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule